// File: doc/BRIEF.md
# Slave Video Sync Recovery and 4:2:2 Pixel Demultiplexer

This block sits at the front of a composite video encoder that is timed by an upstream controller. Every clock carries one byte of a multiplexed 4:2:2 YCbCr stream, plus active-low line and field sync inputs, all on the same pixel clock. The block recovers where each byte falls in the raster: its horizontal position, its line number and its field parity. It supports square-pixel NTSC timing (1560 clocks per line) and square-pixel PAL timing (1888 clocks per line).

Inside the active picture, the block sorts the bytes into chroma and luma slots. It then presents aligned (Y, Cb, Cr) triples with a one-clock valid strobe, two pixels for every four input bytes. Outside the picture it drives blanking codes. Each sync input passes through its own programmable delay of 0 to 7 clocks before it is interpreted. If the syncs stop, the position and line counters keep running on the timing they last saw, so downstream stages still get a stable raster.

Top module: `vid_slave_sync`

## Requirements
- R1: The clock on which the delayed line sync is first sampled low is position 0. `h_pos` reports the position of the byte whose results appear on the outputs in the same cycle. Outputs trail the input byte by two clock edges.
- R2: Position runs 0 to 1559 with `pal_mode`=0 and 0 to 1887 with `pal_mode`=1. It then wraps to 0 and the line number advances by one, even with no line sync edge.
- R3: The first chroma byte of a line sits at position 236 (NTSC) or 310 (PAL). Bytes then repeat in the order chroma-A, Y, chroma-B, Y. `pix_valid` is high on the chroma-B slot (carrying the earlier Y with both chroma bytes) and on the following Y slot (carrying that Y with the same chroma). It is low on the other two slots.
- R4: `active_video` is high for 1280 (NTSC) or 1536 (PAL) positions from the first chroma byte. The last Y of that span still yields a valid pixel.
- R5: Whenever `active_video` is low, `pix_valid` is low, `y_out` is 16 and both chroma outputs are 128.
- R6: A falling edge of the delayed field sync while the delayed line sync is low (including both falling on the same clock) sets `locked`. It makes the current line 4 (NTSC) or 1 (PAL) and marks the field odd.
- R7: While locked, a field-sync fall with the line sync high is accepted only at positions 780..1559 (NTSC) or 944..1887 (PAL). It makes the current line 266 (NTSC) or 313 (PAL). `odd_field` is high only when locked and the line is at most 263 (NTSC) or 312 (PAL).
- R8: A field-sync fall with the line sync high outside that window leaves the line number unchanged.
- R9: With no sync edges, position, line number and pixel slots continue on the last recovered timing.
- R10: `ln_dly` and `fd_dly` delay the line and field sync by that many clocks (0 to 7) before use.
- R11: `cbcr_swap`=0 routes chroma-A to `cb_out` and chroma-B to `cr_out`; `cbcr_swap`=1 exchanges them.
- R12: A change of `pal_mode` clears `locked`, which holds `active_video` and `pix_valid` low until the next odd-field event of R6.
- R13: After reset, `locked`, `odd_field`, `active_video` and `pix_valid` are low, `y_out` is 16 and both chroma outputs are 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 0: NTSC square-pixel timing, 1: PAL |
| cbcr_swap | input | 1 | Exchange the two chroma slots |
| ln_dly | input | DLY_W | Line sync delay in clocks |
| fd_dly | input | DLY_W | Field sync delay in clocks |
| pix_in | input | DATA_W | Multiplexed 4:2:2 byte stream |
| line_sync_n | input | 1 | Line sync, active low |
| field_sync_n | input | 1 | Field sync, active low |
| y_out | output | DATA_W | Luma sample |
| cb_out | output | DATA_W | Blue-difference sample |
| cr_out | output | DATA_W | Red-difference sample |
| pix_valid | output | 1 | Pixel strobe |
| h_pos | output | H_W | Horizontal position of the current output |
| line_num | output | L_W | Line number |
| odd_field | output | 1 | High in the odd field |
| locked | output | 1 | Raster anchored by an odd-field event |
| active_video | output | 1 | Inside the active picture |

## Verification
Four properties are checked on every clock. Position stays below the line length of the current standard. Blanking codes hold whenever the picture is inactive. Pixel strobes come in adjacent pairs only inside a locked active area. Every rise of `locked` lands on the odd-field anchor line. The remaining behaviour can only be shown by the bench's scenarios: exact slot positions under different sync delays, chroma routing with and without the swap, acceptance or rejection of the second-field event by its position, free-running across a line without syncs, and loss of lock on a standard change.

// File: rtl/vss_pkg.sv
package vss_pkg;
    localparam int H_W = 11;
    localparam int L_W = 10;

    localparam int NTSC_HTOT      = 1560;
    localparam int PAL_HTOT       = 1888;
    localparam int NTSC_ACT_START = 236;
    localparam int PAL_ACT_START  = 310;
    localparam int NTSC_PIX       = 640;
    localparam int PAL_PIX        = 768;
    localparam int NTSC_LINES     = 525;
    localparam int PAL_LINES      = 625;
    localparam int NTSC_ODD_LINE  = 4;
    localparam int PAL_ODD_LINE   = 1;
    localparam int NTSC_EVEN_LINE = 266;
    localparam int PAL_EVEN_LINE  = 313;
    localparam int NTSC_EVEN_WIN  = 780;
    localparam int PAL_EVEN_WIN   = 944;
    localparam int NTSC_ODD_LAST  = 263;
    localparam int PAL_ODD_LAST   = 312;
    localparam int Y_BLANK        = 16;
    localparam int C_BLANK        = 128;

    typedef struct packed {
        logic [H_W-1:0] h;
        logic [L_W-1:0] line;
        logic           odd;
        logic           locked;
        logic           active;
    } tpos_t;
endpackage

// File: rtl/vss_sync_delay.sv
module vss_sync_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [DLY_W-1:0] sel,
    output logic             sync_out
);
    localparam int DEPTH = 1 << DLY_W;

    logic [DEPTH-2:0] sh_q, sh_d;
    logic [DEPTH-1:0] taps;

    always_comb begin
        sh_d = {sh_q[DEPTH-3:0], sync_in};
    end

    assign taps     = {sh_q, sync_in};
    assign sync_out = taps[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/vss_timing.sv
module vss_timing
    import vss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pal,
    input  logic  ls_n,
    input  logic  fs_n,
    output tpos_t pos
);
    typedef struct packed {
        tpos_t p;
        logic  mode;
        logic  ls_prev;
        logic  fs_prev;
    } tim_t;

    localparam tim_t TIM_RST = '{p: '{line: L_W'(1), default: '0},
                                 ls_prev: 1'b1, fs_prev: 1'b1, default: '0};

    tim_t q, d;
    logic ls_fall, fs_fall;
    logic [H_W-1:0] h_last, a_first, a_end, e_win;
    logic [L_W-1:0] l_total, l_anchor, l_even, l_odd_last;

    assign ls_fall    = q.ls_prev & ~ls_n;
    assign fs_fall    = q.fs_prev & ~fs_n;
    assign h_last     = pal ? H_W'(PAL_HTOT - 1) : H_W'(NTSC_HTOT - 1);
    assign a_first    = pal ? H_W'(PAL_ACT_START) : H_W'(NTSC_ACT_START);
    assign a_end      = pal ? H_W'(PAL_ACT_START + 2 * PAL_PIX)
                            : H_W'(NTSC_ACT_START + 2 * NTSC_PIX);
    assign e_win      = pal ? H_W'(PAL_EVEN_WIN) : H_W'(NTSC_EVEN_WIN);
    assign l_total    = pal ? L_W'(PAL_LINES) : L_W'(NTSC_LINES);
    assign l_anchor   = pal ? L_W'(PAL_ODD_LINE) : L_W'(NTSC_ODD_LINE);
    assign l_even     = pal ? L_W'(PAL_EVEN_LINE) : L_W'(NTSC_EVEN_LINE);
    assign l_odd_last = pal ? L_W'(PAL_ODD_LAST) : L_W'(NTSC_ODD_LAST);

    always_comb begin
        d         = q;
        d.ls_prev = ls_n;
        d.fs_prev = fs_n;
        d.mode    = pal;
        if (pal != q.mode) begin
            d.p.h      = '0;
            d.p.line   = L_W'(1);
            d.p.locked = 1'b0;
        end else begin
            // a sync edge and a natural wrap on the same clock advance once
            if (ls_fall || q.p.h == h_last) begin
                d.p.h    = '0;
                d.p.line = (q.p.line >= l_total) ? L_W'(1) : q.p.line + 1'b1;
            end else begin
                d.p.h = q.p.h + 1'b1;
            end
            if (fs_fall && !ls_n) begin
                d.p.line   = l_anchor;
                d.p.locked = 1'b1;
            end else if (fs_fall && q.p.locked && d.p.h >= e_win) begin
                d.p.line = l_even;
            end
        end
        d.p.odd    = d.p.locked && (d.p.line <= l_odd_last);
        d.p.active = d.p.locked && (d.p.h >= a_first) && (d.p.h < a_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TIM_RST;
        else        q <= d;
    end

    assign pos = q.p;
endmodule

// File: rtl/vss_demux.sv
module vss_demux
    import vss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal,
    input  logic              swap,
    input  logic [DATA_W-1:0] din,
    input  tpos_t             pos_in,
    output tpos_t             pos_out,
    output logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] cb,
    output logic [DATA_W-1:0] cr,
    output logic              valid
);
    localparam logic [DATA_W-1:0] YB = DATA_W'(Y_BLANK << (DATA_W - 8));
    localparam logic [DATA_W-1:0] CB = DATA_W'(C_BLANK << (DATA_W - 8));

    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] ca;
        logic [DATA_W-1:0] cbk;
        logic [DATA_W-1:0] yh;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] cb;
        logic [DATA_W-1:0] cr;
        logic              valid;
        tpos_t             pos;
    } dmx_t;

    localparam dmx_t DMX_RST = '{y: YB, cb: CB, cr: CB, default: '0};

    dmx_t q, d;
    logic [H_W-1:0] a_first;
    logic [1:0]     slot;

    assign a_first = pal ? H_W'(PAL_ACT_START) : H_W'(NTSC_ACT_START);
    assign slot    = 2'(pos_in.h - a_first);

    always_comb begin
        d       = q;
        d.dat   = din;
        d.pos   = pos_in;
        d.valid = 1'b0;
        if (!pos_in.active) begin
            d.y  = YB;
            d.cb = CB;
            d.cr = CB;
        end else begin
            case (slot)
                2'd0: d.ca = q.dat;
                2'd1: d.yh = q.dat;
                2'd2: begin
                    d.cbk   = q.dat;
                    d.y     = q.yh;
                    d.cb    = swap ? q.dat : q.ca;
                    d.cr    = swap ? q.ca  : q.dat;
                    d.valid = 1'b1;
                end
                default: begin
                    d.y     = q.dat;
                    d.cb    = swap ? q.cbk : q.ca;
                    d.cr    = swap ? q.ca  : q.cbk;
                    d.valid = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= DMX_RST;
        else        q <= d;
    end

    assign pos_out = q.pos;
    assign y       = q.y;
    assign cb      = q.cb;
    assign cr      = q.cr;
    assign valid   = q.valid;
endmodule

// File: rtl/vid_slave_sync.sv
module vid_slave_sync
    import vss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    input  logic              cbcr_swap,
    input  logic [DLY_W-1:0]  ln_dly,
    input  logic [DLY_W-1:0]  fd_dly,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              line_sync_n,
    input  logic              field_sync_n,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W-1:0] cb_out,
    output logic [DATA_W-1:0] cr_out,
    output logic              pix_valid,
    output logic [H_W-1:0]    h_pos,
    output logic [L_W-1:0]    line_num,
    output logic              odd_field,
    output logic              locked,
    output logic              active_video
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0]       sync_raw, sync_dl;
    logic [N_SYNC-1:0][DLY_W-1:0] sync_sel;
    tpos_t                   tpos, opos;

    assign sync_raw = {field_sync_n, line_sync_n};
    assign sync_sel = {fd_dly, ln_dly};

    for (genvar i = 0; i < N_SYNC; i++) begin : g_dly
        vss_sync_delay #(.DLY_W(DLY_W)) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_raw[i]),
            .sel     (sync_sel[i]),
            .sync_out(sync_dl[i])
        );
    end

    vss_timing u_tim (
        .clk  (clk),
        .rst_n(rst_n),
        .pal  (pal_mode),
        .ls_n (sync_dl[0]),
        .fs_n (sync_dl[1]),
        .pos  (tpos)
    );

    vss_demux #(.DATA_W(DATA_W)) u_dmx (
        .clk    (clk),
        .rst_n  (rst_n),
        .pal    (pal_mode),
        .swap   (cbcr_swap),
        .din    (pix_in),
        .pos_in (tpos),
        .pos_out(opos),
        .y      (y_out),
        .cb     (cb_out),
        .cr     (cr_out),
        .valid  (pix_valid)
    );

    assign h_pos        = opos.h;
    assign line_num     = opos.line;
    assign odd_field    = opos.odd;
    assign locked       = opos.locked;
    assign active_video = opos.active;
endmodule

// File: rtl/vss_checker.sv
module vss_checker
    import vss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pal_mode,
    input logic [DATA_W-1:0] y_out,
    input logic [DATA_W-1:0] cb_out,
    input logic [DATA_W-1:0] cr_out,
    input logic              pix_valid,
    input logic [H_W-1:0]    h_pos,
    input logic [L_W-1:0]    line_num,
    input logic              odd_field,
    input logic              locked,
    input logic              active_video
);
    localparam logic [DATA_W-1:0] YB = DATA_W'(Y_BLANK << (DATA_W - 8));
    localparam logic [DATA_W-1:0] CB = DATA_W'(C_BLANK << (DATA_W - 8));

    assert_hpos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $stable(pal_mode) && $past(pal_mode) == $past(pal_mode, 2) |->
            h_pos <= ($past(pal_mode, 2) ? H_W'(PAL_HTOT - 1) : H_W'(NTSC_HTOT - 1)));

    assert_blank_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_video |-> !pix_valid && y_out == YB && cb_out == CB && cr_out == CB);

    assert_pair_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !$past(pix_valid) |=> pix_valid);

    assert_pair_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && $past(pix_valid) |=> !pix_valid);

    assert_valid_needs_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> active_video && locked);

    assert_lock_anchor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> odd_field &&
            (line_num == L_W'(NTSC_ODD_LINE) || line_num == L_W'(PAL_ODD_LINE)));
endmodule

bind vid_slave_sync vss_checker #(.DATA_W(DATA_W)) u_vss_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pal_mode    (pal_mode),
    .y_out       (y_out),
    .cb_out      (cb_out),
    .cr_out      (cr_out),
    .pix_valid   (pix_valid),
    .h_pos       (h_pos),
    .line_num    (line_num),
    .odd_field   (odd_field),
    .locked      (locked),
    .active_video(active_video)
);

// File: tb/vid_slave_sync_bench.sv
module vid_slave_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_mode = 1'b0;
    logic        cbcr_swap = 1'b0;
    logic [2:0]  ln_dly = '0;
    logic [2:0]  fd_dly = '0;
    logic [7:0]  pix_in = 8'h10;
    logic        line_sync_n = 1'b1;
    logic        field_sync_n = 1'b1;
    logic [7:0]  y_out, cb_out, cr_out;
    logic        pix_valid, odd_field, locked, active_video;
    logic [10:0] h_pos;
    logic [9:0]  line_num;

    always #2.5 clk = ~clk;

    vid_slave_sync u_vid_slave_sync (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .cbcr_swap(cbcr_swap),
        .ln_dly(ln_dly), .fd_dly(fd_dly), .pix_in(pix_in),
        .line_sync_n(line_sync_n), .field_sync_n(field_sync_n),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .pix_valid(pix_valid),
        .h_pos(h_pos), .line_num(line_num), .odd_field(odd_field),
        .locked(locked), .active_video(active_video)
    );

    typedef struct packed {
        bit       pal;
        bit       swap;
        bit [2:0] hd;
        bit [2:0] vd;
        bit [7:0] vp;
        bit [9:0] exp_line;
    } vec_t;

    // standard, swap, line delay, field delay, field-sync fall position, line expected after anchor
    localparam vec_t VEC [4] = '{
        '{1'b0, 1'b0, 3'd0, 3'd0, 8'd20, 10'd5},
        '{1'b1, 1'b1, 3'd0, 3'd0, 8'd0,  10'd2},
        '{1'b0, 1'b1, 3'd5, 3'd2, 8'd30, 10'd5},
        '{1'b1, 1'b0, 3'd7, 3'd7, 8'd10, 10'd2}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit g_pal, g_swap;
    int g_hd;
    int exp_line;
    bit late_en;
    int late_line;
    bit seen_valid;

    function automatic int pat(int p);
        return (p * 13 + 7) & 255;
    endfunction

    task automatic expect_eq(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic chk_pos(input int q);
        int h, st, w2, ca, cbk, ecb, ecr, odd_exp;
        h   = q - g_hd;
        st  = g_pal ? 310 : 236;
        w2  = g_pal ? 1536 : 1280;
        odd_exp = (exp_line <= (g_pal ? 312 : 263)) ? 1 : 0;
        if (h == st - 1) begin
            expect_eq("R5 valid before picture", int'(pix_valid), 0);
            expect_eq("R5 luma blank before picture", int'(y_out), 16);
            expect_eq("R5 cb blank before picture", int'(cb_out), 128);
            expect_eq("R5 cr blank before picture", int'(cr_out), 128);
            expect_eq("R4 inactive before first chroma", int'(active_video), 0);
        end
        if (h == st + 1) begin
            expect_eq("R3 no strobe on first Y slot", int'(pix_valid), 0);
            expect_eq("R4 active from first chroma", int'(active_video), 1);
        end
        if (h == st + 2) begin
            ca  = pat(q - 2);
            cbk = pat(q);
            ecb = g_swap ? cbk : ca;
            ecr = g_swap ? ca : cbk;
            expect_eq("R1 R10 h_pos at chroma-B slot", int'(h_pos), h);
            expect_eq("R3 R10 strobe on chroma-B slot", int'(pix_valid), 1);
            expect_eq("R3 R10 first luma", int'(y_out), pat(q - 1));
            expect_eq("R11 cb routing", int'(cb_out), ecb);
            expect_eq("R11 cr routing", int'(cr_out), ecr);
            expect_eq("R6 R9 line number", int'(line_num), exp_line);
            expect_eq("R7 odd flag", int'(odd_field), odd_exp);
            expect_eq("R6 locked", int'(locked), 1);
        end
        if (h == st + 3) begin
            ca  = pat(q - 3);
            cbk = pat(q - 1);
            expect_eq("R3 strobe on second Y slot", int'(pix_valid), 1);
            expect_eq("R3 second luma", int'(y_out), pat(q));
            expect_eq("R11 cb held for second pixel", int'(cb_out), g_swap ? cbk : ca);
        end
        if (h == st + w2 - 1) begin
            expect_eq("R4 last pixel strobe", int'(pix_valid), 1);
            expect_eq("R4 last pixel luma", int'(y_out), pat(q));
        end
        if (h == st + w2) begin
            expect_eq("R4 inactive after picture", int'(active_video), 0);
            expect_eq("R5 valid after picture", int'(pix_valid), 0);
            expect_eq("R5 luma blank after picture", int'(y_out), 16);
        end
        if (late_en && h == 1000) begin
            expect_eq("R7 R8 line after second-field event", int'(line_num), late_line);
            expect_eq("R7 R8 even field flag", int'(odd_field), 0);
        end
    endtask

    task automatic drive_line(input bit ls_on, input int vfall, input bit chk);
        int tot;
        tot = g_pal ? 1888 : 1560;
        for (int p = 0; p < tot; p++) begin
            @(negedge clk);
            if (pix_valid) seen_valid = 1'b1;
            if (chk && p >= 2) chk_pos(p - 2);
            line_sync_n  = ls_on ? (p >= 115) : 1'b1;
            field_sync_n = !(vfall >= 0 && p >= vfall && p < vfall + 40);
            pix_in       = 8'(pat(p));
        end
    endtask

    task automatic do_reset(input bit pal, input bit swap, input int hd, input int vd);
        rst_n        = 1'b0;
        pal_mode     = pal;
        cbcr_swap    = swap;
        ln_dly       = 3'(hd);
        fd_dly       = 3'(vd);
        line_sync_n  = 1'b1;
        field_sync_n = 1'b1;
        g_pal        = pal;
        g_swap       = swap;
        g_hd         = hd;
        late_en      = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R13 reset state
        do_reset(1'b0, 1'b0, 0, 0);
        repeat (2) @(negedge clk);
        expect_eq("R13 locked after reset", int'(locked), 0);
        expect_eq("R13 odd flag after reset", int'(odd_field), 0);
        expect_eq("R13 active after reset", int'(active_video), 0);
        expect_eq("R13 valid after reset", int'(pix_valid), 0);
        expect_eq("R13 luma after reset", int'(y_out), 16);
        expect_eq("R13 cb after reset", int'(cb_out), 128);
        expect_eq("R13 cr after reset", int'(cr_out), 128);

        // table: anchor line, then a fully checked line
        for (int i = 0; i < 4; i++) begin
            do_reset(VEC[i].pal, VEC[i].swap, int'(VEC[i].hd), int'(VEC[i].vd));
            drive_line(1'b1, int'(VEC[i].vp), 1'b0);
            exp_line = int'(VEC[i].exp_line);
            drive_line(1'b1, -1, 1'b1);
        end

        // free-running line and second-field events, NTSC
        do_reset(1'b0, 1'b0, 0, 0);
        drive_line(1'b1, 20, 1'b0);
        exp_line = 5;
        drive_line(1'b1, -1, 1'b1);
        exp_line = 6;                       // R9 R2 no line sync at all
        drive_line(1'b0, -1, 1'b1);
        exp_line  = 7;                      // R7 accepted at position 800
        late_en   = 1'b1;
        late_line = 266;
        drive_line(1'b1, 800, 1'b1);
        exp_line  = 267;                    // R8 ignored at position 500
        late_line = 267;
        drive_line(1'b1, 500, 1'b1);
        late_en = 1'b0;

        // R12 standard change drops lock
        @(negedge clk);
        pal_mode = 1'b1;
        g_pal    = 1'b1;
        repeat (3) @(negedge clk);
        expect_eq("R12 lock lost on standard change", int'(locked), 0);
        expect_eq("R12 inactive on standard change", int'(active_video), 0);
        seen_valid = 1'b0;
        drive_line(1'b1, -1, 1'b0);
        expect_eq("R12 no pixels while unlocked", int'(seen_valid), 0);
        drive_line(1'b1, 20, 1'b0);
        exp_line = 2;
        drive_line(1'b1, -1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule